// File: doc/BRIEF.md
# Row-Hit-First Bank Request Scheduler

This block holds pending memory requests for several DRAM banks and, when asked, chooses the next request for one bank. Each request carries a bank index, a row address and an opaque tag. The requests for each bank sit in their own small buffer, and the buffer keeps the order in which they arrived. The block performs no command timing and no data movement. It only decides which queued request a bank should serve next.

A select names a bank and gives the row that bank has open. The answer comes back combinationally in the same cycle, and the chosen entry is retired at the next clock edge. If the bank is not bound to a row, the block prefers requests that hit the open row. When nothing hits, it opens the row of the bank's oldest request, which counts as an activation. Once a row is chosen, the bank stays bound to it and serves every queued request to that row, oldest first, before it looks at any other row. A global pending count and a set of per-bank counters report traffic: activations, accesses, accesses since the last activation, and the peak of that last figure.

Top module: `rhf_sched`

## Requirements
- R1: `req_ready_o` is low exactly when the bank named by `req_bank_i` already holds DEPTH requests. A request offered while ready is low is dropped, and `pending_o` does not change.
- R2: When an unbound bank is selected and at least one of its requests targets `sel_open_row_i`, the oldest such request is returned with `sel_act_o` = 0.
- R3: When an unbound bank is selected and none of its requests targets the open row, the oldest request of that bank is returned with `sel_act_o` = 1.
- R4: After a grant, if requests to the granted row remain in that bank, the following selects of that bank return them oldest first, with `sel_act_o` = 0, whatever `sel_open_row_i` is.
- R5: The binding ends after the last request to the bound row is granted. The next select of that bank is then decided again by R2 or R3.
- R6: A select of a bank with no queued request gives `sel_grant_o` = 0 and `sel_act_o` = 0.
- R7: A request accepted in a cycle cannot be granted in that same cycle. It becomes selectable from the next cycle on.
- R8: `pending_o` rises by one for each accepted request and falls by one for each grant. A grant never happens while `pending_o` is zero.
- R9: For each bank b, the slice [b*CNT_W +: CNT_W] of `act_cnt_o` counts grants with `sel_act_o` = 1. The same slice of `acc_cnt_o` counts all grants to that bank.
- R10: For each bank, `cur_acc_o` counts the grants since the last activation, and an activating grant sets it to 1. On each activation, `peak_acc_o` takes the larger of its own value and the `cur_acc_o` value from before that grant.
- R11: The buffers, bindings and counters of different banks are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Offer a new request |
| req_ready_o | output | 1 | Target bank has a free entry |
| req_bank_i | input | BANK_W | Bank of the new request |
| req_row_i | input | ROW_W | Row of the new request |
| req_tag_i | input | TAG_W | Tag of the new request |
| sel_valid_i | input | 1 | Select strobe |
| sel_bank_i | input | BANK_W | Bank being selected |
| sel_open_row_i | input | ROW_W | Row currently open in that bank |
| sel_grant_o | output | 1 | A request is returned |
| sel_act_o | output | 1 | The grant needs a row activation |
| sel_row_o | output | ROW_W | Row of the granted request |
| sel_tag_o | output | TAG_W | Tag of the granted request |
| pending_o | output | PEND_W | Requests held across all banks |
| act_cnt_o | output | NUM_BANKS*CNT_W | Per-bank activation counts |
| acc_cnt_o | output | NUM_BANKS*CNT_W | Per-bank access counts |
| cur_acc_o | output | NUM_BANKS*CNT_W | Per-bank accesses since the last activation |
| peak_acc_o | output | NUM_BANKS*CNT_W | Per-bank peak of accesses per activation |

## Verification
The bench builds the block with four banks and DEPTH reduced to 4. With that depth a bank fills after four inserts, so back-pressure and the rejected-insert path can be reached in a short run. With four entries a bank can also hold two rows interleaved. That interleaving exercises preference for the open row, holding a bound row while the open row moves, release of the binding, and fallback to the oldest request, all inside one buffer. Separate banks carry separate scenarios, so each bank's counters can be checked against a hand-computed history.

// File: rtl/rhf_pkg.sv
package rhf_pkg;
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_LOCK,
    SRC_OPEN,
    SRC_OLDEST
  } tgt_src_e;
endpackage

// File: rtl/rhf_bank_queue.sv
module rhf_bank_queue
  import rhf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ROW_W = 12,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic [ROW_W-1:0] ins_row_i,
  input  logic [TAG_W-1:0] ins_tag_i,
  output logic             full_o,
  input  logic             deq_i,
  input  logic [ROW_W-1:0] open_row_i,
  output logic             pick_valid_o,
  output logic             activate_o,
  output logic [ROW_W-1:0] pick_row_o,
  output logic [TAG_W-1:0] pick_tag_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int AGE_W = $clog2(DEPTH + 1);

  logic             valid_q [DEPTH];
  logic [ROW_W-1:0] row_q   [DEPTH];
  logic [TAG_W-1:0] tag_q   [DEPTH];
  logic [AGE_W-1:0] age_q   [DEPTH];
  logic             lock_v_q;
  logic [ROW_W-1:0] lock_row_q;

  logic [AGE_W-1:0] cnt, same_cnt, best_age;
  logic [IDX_W-1:0] best_idx, free_idx;
  logic             hit_open, found;
  logic [ROW_W-1:0] oldest_row, tgt_row;
  tgt_src_e         src;

  always_comb begin
    cnt        = '0;
    hit_open   = 1'b0;
    oldest_row = '0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      cnt = cnt + AGE_W'(valid_q[i]);
      if (valid_q[i] && row_q[i] == open_row_i) hit_open = 1'b1;
      if (valid_q[i] && age_q[i] == '0) oldest_row = row_q[i];
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign full_o = (cnt == AGE_W'(DEPTH));

  // target row: bound row, else open-row hit, else oldest entry's row
  always_comb begin
    if (lock_v_q) begin
      src = SRC_LOCK;     tgt_row = lock_row_q;
    end else if (hit_open) begin
      src = SRC_OPEN;     tgt_row = open_row_i;
    end else if (cnt != '0) begin
      src = SRC_OLDEST;   tgt_row = oldest_row;
    end else begin
      src = SRC_NONE;     tgt_row = '0;
    end
  end

  // oldest entry inside the target row group
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_age = '1;
    same_cnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && row_q[i] == tgt_row && src != SRC_NONE) begin
        same_cnt = same_cnt + AGE_W'(1);
        if (!found || age_q[i] < best_age) begin
          found    = 1'b1;
          best_idx = IDX_W'(i);
          best_age = age_q[i];
        end
      end
    end
  end

  assign pick_valid_o = found;
  assign activate_o   = found && (src == SRC_OLDEST);
  assign pick_row_o   = row_q[best_idx];
  assign pick_tag_o   = tag_q[best_idx];

  wire do_deq = deq_i && found;
  wire do_ins = ins_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        row_q[i]   <= '0;
        tag_q[i]   <= '0;
        age_q[i]   <= '0;
      end
      lock_v_q   <= 1'b0;
      lock_row_q <= '0;
    end else begin
      if (do_deq) begin
        valid_q[best_idx] <= 1'b0;
        for (int i = 0; i < DEPTH; i++)
          if (valid_q[i] && age_q[i] > best_age) age_q[i] <= age_q[i] - AGE_W'(1);
        lock_v_q   <= (same_cnt > AGE_W'(1));
        lock_row_q <= tgt_row;
      end
      if (do_ins) begin
        valid_q[free_idx] <= 1'b1;
        row_q[free_idx]   <= ins_row_i;
        tag_q[free_idx]   <= ins_tag_i;
        age_q[free_idx]   <= cnt - AGE_W'(do_deq);
      end
    end
  end
endmodule

// File: rtl/rhf_bank_stats.sv
module rhf_bank_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             act_i,
  output logic [CNT_W-1:0] act_cnt_o,
  output logic [CNT_W-1:0] acc_cnt_o,
  output logic [CNT_W-1:0] cur_acc_o,
  output logic [CNT_W-1:0] peak_acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cnt_o  <= '0;
      acc_cnt_o  <= '0;
      cur_acc_o  <= '0;
      peak_acc_o <= '0;
    end else if (acc_i) begin
      acc_cnt_o <= acc_cnt_o + CNT_W'(1);
      if (act_i) begin
        act_cnt_o <= act_cnt_o + CNT_W'(1);
        cur_acc_o <= CNT_W'(1);
        if (cur_acc_o > peak_acc_o) peak_acc_o <= cur_acc_o;
      end else begin
        cur_acc_o <= cur_acc_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rhf_sched.sv
module rhf_sched #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 12,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PEND_W   = $clog2(NUM_BANKS * DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [BANK_W-1:0]          req_bank_i,
  input  logic [ROW_W-1:0]           req_row_i,
  input  logic [TAG_W-1:0]           req_tag_i,
  input  logic                       sel_valid_i,
  input  logic [BANK_W-1:0]          sel_bank_i,
  input  logic [ROW_W-1:0]           sel_open_row_i,
  output logic                       sel_grant_o,
  output logic                       sel_act_o,
  output logic [ROW_W-1:0]           sel_row_o,
  output logic [TAG_W-1:0]           sel_tag_o,
  output logic [PEND_W-1:0]          pending_o,
  output logic [NUM_BANKS*CNT_W-1:0] act_cnt_o,
  output logic [NUM_BANKS*CNT_W-1:0] acc_cnt_o,
  output logic [NUM_BANKS*CNT_W-1:0] cur_acc_o,
  output logic [NUM_BANKS*CNT_W-1:0] peak_acc_o
);
  logic             full   [NUM_BANKS];
  logic             pick_v [NUM_BANKS];
  logic             pick_a [NUM_BANKS];
  logic [ROW_W-1:0] pick_r [NUM_BANKS];
  logic [TAG_W-1:0] pick_t [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wire ins = req_valid_i && (req_bank_i == BANK_W'(b));
    wire deq = sel_valid_i && (sel_bank_i == BANK_W'(b));

    rhf_bank_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W)) i_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ins_i       (ins),
      .ins_row_i   (req_row_i),
      .ins_tag_i   (req_tag_i),
      .full_o      (full[b]),
      .deq_i       (deq),
      .open_row_i  (sel_open_row_i),
      .pick_valid_o(pick_v[b]),
      .activate_o  (pick_a[b]),
      .pick_row_o  (pick_r[b]),
      .pick_tag_o  (pick_t[b])
    );

    rhf_bank_stats #(.CNT_W(CNT_W)) i_stats (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acc_i     (deq && pick_v[b]),
      .act_i     (pick_a[b]),
      .act_cnt_o (act_cnt_o[b*CNT_W +: CNT_W]),
      .acc_cnt_o (acc_cnt_o[b*CNT_W +: CNT_W]),
      .cur_acc_o (cur_acc_o[b*CNT_W +: CNT_W]),
      .peak_acc_o(peak_acc_o[b*CNT_W +: CNT_W])
    );
  end

  assign req_ready_o = !full[req_bank_i];
  assign sel_grant_o = sel_valid_i && pick_v[sel_bank_i];
  assign sel_act_o   = sel_valid_i && pick_a[sel_bank_i];
  assign sel_row_o   = pick_r[sel_bank_i];
  assign sel_tag_o   = pick_t[sel_bank_i];

  wire accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pending_o <= '0;
    else if (accept && !sel_grant_o) pending_o <= pending_o + PEND_W'(1);
    else if (!accept && sel_grant_o) pending_o <= pending_o - PEND_W'(1);
  end
endmodule

// File: rtl/rhf_sched_chk.sv
module rhf_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 12,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 16,
  parameter int BANK_W    = 2,
  parameter int PEND_W    = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_valid_i,
  input logic                       req_ready_o,
  input logic [BANK_W-1:0]          sel_bank_i,
  input logic                       sel_grant_o,
  input logic                       sel_act_o,
  input logic [PEND_W-1:0]          pending_o,
  input logic [NUM_BANKS*CNT_W-1:0] act_cnt_o,
  input logic [NUM_BANKS*CNT_W-1:0] cur_acc_o
);
  // R8
  a_r8_grant_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_grant_o |-> pending_o != '0);

  a_r8_pending_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !sel_grant_o) |=> pending_o == $past(pending_o) + PEND_W'(1));

  a_r8_pending_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_valid_i && req_ready_o) && sel_grant_o) |=> pending_o == $past(pending_o) - PEND_W'(1));

  // R6
  a_r6_no_act_without_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_grant_o |-> !sel_act_o);

  // R9
  a_r9_act_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_grant_o && sel_act_o) |=>
      act_cnt_o[$past(sel_bank_i)*CNT_W +: CNT_W] ==
      $past(act_cnt_o[sel_bank_i*CNT_W +: CNT_W]) + CNT_W'(1));

  // R10
  a_r10_cur_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_grant_o && sel_act_o) |=> cur_acc_o[$past(sel_bank_i)*CNT_W +: CNT_W] == CNT_W'(1));
endmodule

bind rhf_sched rhf_sched_chk #(
  .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W),
  .CNT_W(CNT_W), .BANK_W(BANK_W), .PEND_W(PEND_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .sel_bank_i (sel_bank_i),
  .sel_grant_o(sel_grant_o),
  .sel_act_o  (sel_act_o),
  .pending_o  (pending_o),
  .act_cnt_o  (act_cnt_o),
  .cur_acc_o  (cur_acc_o)
);

// File: tb/test_rhf_sched.sv
`timescale 1ns/1ps
module test_rhf_sched;
  localparam int NB = 4, DP = 4, RW = 12, TW = 8, CW = 16;
  localparam int BW = 2, PW = $clog2(NB * DP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, sel_valid = 1'b0;
  logic [BW-1:0] req_bank = '0, sel_bank = '0;
  logic [RW-1:0] req_row = '0, sel_row_in = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_ready, grant, act;
  logic [RW-1:0] g_row;
  logic [TW-1:0] g_tag;
  logic [PW-1:0] pending;
  logic [NB*CW-1:0] act_cnt, acc_cnt, cur_acc, peak_acc;

  int vectors = 0, fails = 0, exp_pend = 0;

  always #5 clk = ~clk;

  rhf_sched #(.NUM_BANKS(NB), .DEPTH(DP), .ROW_W(RW), .TAG_W(TW), .CNT_W(CW)) i_rhf_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_tag_i(req_tag),
    .sel_valid_i(sel_valid), .sel_bank_i(sel_bank), .sel_open_row_i(sel_row_in),
    .sel_grant_o(grant), .sel_act_o(act), .sel_row_o(g_row), .sel_tag_o(g_tag),
    .pending_o(pending), .act_cnt_o(act_cnt), .acc_cnt_o(acc_cnt),
    .cur_acc_o(cur_acc), .peak_acc_o(peak_acc)
  );

  task automatic check(string req, int actual, int expected);
    vectors++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic push(int b, int row, int tag);
    @(negedge clk);
    req_valid = 1'b1; req_bank = BW'(b); req_row = RW'(row); req_tag = TW'(tag);
    #1 check("R1 ready on free bank", int'(req_ready), 1);
    @(posedge clk); #1 req_valid = 1'b0;
    exp_pend++;
  endtask

  task automatic sel(int b, int open, bit eg, int erow, int etag, bit eact, string req);
    @(negedge clk);
    sel_valid = 1'b1; sel_bank = BW'(b); sel_row_in = RW'(open);
    #1;
    check({req, " grant"}, int'(grant), int'(eg));
    check({req, " act"}, int'(act), int'(eact));
    if (eg) begin
      check({req, " row"}, int'(g_row), erow);
      check({req, " tag"}, int'(g_tag), etag);
      exp_pend--;
    end
    @(posedge clk); #1 sel_valid = 1'b0;
  endtask

  task automatic chk_stats(int b, int ea, int ec, int ecur, int epk, string req);
    @(negedge clk);
    check({req, " act_cnt"},  int'(act_cnt[b*CW +: CW]),  ea);
    check({req, " acc_cnt"},  int'(acc_cnt[b*CW +: CW]),  ec);
    check({req, " cur_acc"},  int'(cur_acc[b*CW +: CW]),  ecur);
    check({req, " peak_acc"}, int'(peak_acc[b*CW +: CW]), epk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 pending after reset", int'(pending), 0);
    check("R1 ready after reset", int'(req_ready), 1);
    sel(0, 0, 0, 0, 0, 0, "R6 select empty after reset");
  endtask

  task automatic t_open_hit_and_fallback;
    push(0, 5, 1); push(0, 7, 2); push(0, 5, 3);
    sel(0, 7, 1, 7, 2, 0, "R2 open-row hit");
    sel(0, 9, 1, 5, 1, 1, "R3 fallback to oldest, R5 re-evaluated");
    sel(0, 7, 1, 5, 3, 0, "R4 bound row held");
    sel(0, 7, 0, 0, 0, 0, "R6 drained bank");
    chk_stats(0, 1, 3, 2, 1, "R9 R10 bank0");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'd1; req_row = 12'd3; req_tag = 8'd4;
    sel_valid = 1'b1; sel_bank = 2'd1; sel_row_in = 12'd3;
    #1 check("R7 no grant same cycle", int'(grant), 0);
    @(posedge clk); #1 req_valid = 1'b0; sel_valid = 1'b0;
    exp_pend++;
    @(negedge clk) check("R8 pending after insert", int'(pending), exp_pend);
    sel(1, 0, 1, 3, 4, 1, "R7 grant next cycle");
    chk_stats(1, 1, 1, 1, 0, "R9 R10 bank1");
    chk_stats(0, 1, 3, 2, 1, "R11 bank0 untouched");
  endtask

  task automatic t_full_and_lock;
    push(2, 1, 10); push(2, 2, 11); push(2, 1, 12); push(2, 2, 13);
    @(negedge clk);
    req_bank = 2'd2; req_row = 12'd9; req_tag = 8'd99;
    #1 check("R1 ready low on full bank", int'(req_ready), 0);
    req_bank = 2'd3;
    #1 check("R11 ready high on other bank", int'(req_ready), 1);
    req_bank = 2'd2; req_valid = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk) check("R1 rejected insert leaves pending", int'(pending), exp_pend);
    sel(2, 2, 1, 2, 11, 0, "R2 hit picks oldest of row");
    sel(2, 1, 1, 2, 13, 0, "R4 bound while open row moves");
    sel(2, 2, 1, 1, 10, 1, "R5 released then R3 fallback");
    sel(2, 2, 1, 1, 12, 0, "R4 new binding drained");
    sel(2, 1, 0, 0, 0, 0, "R6 bank2 empty");
    chk_stats(2, 1, 4, 2, 2, "R10 peak bank2");
    @(negedge clk) check("R8 pending back to zero", int'(pending), 0);
    check("R8 bench pending model", exp_pend, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_open_hit_and_fallback();
    t_same_cycle();
    t_full_and_lock();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule